// File: doc/BRIEF.md
# DMA Channel Completion and Interrupt Flag Bank

This block keeps two flags per channel for a 64-channel DMA controller: a transfer-complete (done) flag and an interrupt-request flag. The transfer engine raises either flag for any set of channels with one-cycle pulses. Software lowers flags over a small 32-bit word-addressed register bus. It has two ways to do this.

The first way is a command word whose byte lanes each carry an indexed clear command. Each command can skip itself, clear one channel, or clear every channel, so one channel can be cleared without a read-modify-write. The second way is a pair of interrupt bitmap words with write-one-to-clear semantics. The 64 interrupt flags also leave the block directly as a vector toward the interrupt controller.

Reads are combinational from the word address. The done flags can be read back, and the command word always reads as zero.

Top module: `dma_flag_status`

## Requirements
- R1: After a synchronous active-high reset, every done flag and every interrupt flag is 0, and every readable word returns 0.
- R2: A 1 on bit k of `set_done_i` or `set_irq_i` in a cycle makes the matching flag of channel k read 1 from the next cycle, and the flag holds until a clear acts on it.
- R3: A write to word address 4 with byte enable 0 set decodes bits 7:0 as a clear-done command. Bit 7 is the skip flag, bit 6 is the all flag, and bits 5:0 are the channel index. With bits 7 and 6 both 0, only the indexed channel's done flag is cleared.
- R4: A clear-done command with bit 7 at 0 and bit 6 at 1 clears every done flag, whatever bits 5:0 hold.
- R5: A command byte with bit 7 set has no effect on any flag. A lane whose byte enable is 0 also has no effect on any flag.
- R6: Bits 15:8 of a write to word address 4, enabled by byte enable 1, form a clear-interrupt command with the same encoding as R3. It clears only interrupt flags: one channel, or all channels when bit 6 is set.
- R7: Word address 0 maps bit i to the interrupt flag of channel i. Word address 1 maps bit i to channel 32+i. Writing 1 to a bit clears that flag, writing 0 leaves it, and only bytes whose enable is set take part.
- R8: Reads return the interrupt flags at addresses 0 and 1 and the done flags at addresses 2 (channels 31..0) and 3 (channels 63..32), with the same bit mapping as R7. Reads of address 4 and of addresses 5 to 7 return 0. Writes to addresses 2, 3 and 5 to 7 change nothing.
- R9: When a set pulse and any software clear target the same flag in the same cycle, the flag ends up 1.
- R10: Both command lanes of one write act in the same cycle, each independently of the other.
- R11: `irq_o` and `done_o` always equal the current flag values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_done_i | input | 64 | Per-channel done set pulses from the engine |
| set_irq_i | input | 64 | Per-channel interrupt set pulses from the engine |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Word address for read and write |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| done_o | output | 64 | Done flags |
| irq_o | output | 64 | Interrupt request vector to the interrupt controller |

## Verification
The bench builds the block with its defaults: 64 channels, 32-bit words and a 3-bit word address. At these values every command index from 0 to 63 and both halves of each flag vector exist, so the boundary channels 0, 31, 32 and 63 can be reached. The 3-bit address also reaches the unmapped addresses 5 to 7, where reads must return zero and writes must have no effect. Random traffic mixes sparse set pulses with command, bitmap and ignored writes, and directed cases pin down the set-over-clear collision and skipped lanes.

// File: rtl/dma_flag_status.sv
module dma_flag_status #(
  parameter int CH = 64,
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CH-1:0] set_done_i,
  input  logic [CH-1:0] set_irq_i,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW/8-1:0] wr_be,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic [CH-1:0] done_o,
  output logic [CH-1:0] irq_o
);
  localparam int WORDS = CH / DW;
  localparam int LANES = DW / 8;
  localparam int IW    = $clog2(CH);
  localparam logic [AW-1:0] CMD_ADDR = AW'(2 * WORDS);

  logic [CH-1:0] done_q, irq_q;
  logic [CH-1:0] clr_done, clr_irq_cmd, clr_irq_map;
  logic [DW-1:0] be_mask;
  logic          cmd_hit;

  function automatic logic [CH-1:0] cmd_mask(input logic [7:0] b, input logic en);
    if (!en || b[7]) return '0;
    if (b[6]) return '1;
    return CH'(1) << b[IW-1:0];
  endfunction

  assign cmd_hit     = wr_en && (addr == CMD_ADDR);
  assign clr_done    = cmd_mask(wr_data[7:0],  cmd_hit && wr_be[0]);
  assign clr_irq_cmd = cmd_mask(wr_data[15:8], cmd_hit && wr_be[1]);

  for (genvar l = 0; l < LANES; l++) begin : g_be
    assign be_mask[l*8 +: 8] = {8{wr_be[l]}};
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_map
    assign clr_irq_map[w*DW +: DW] =
      (wr_en && addr == AW'(w)) ? (wr_data & be_mask) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= '0;
      irq_q  <= '0;
    end else begin
      done_q <= (done_q & ~clr_done) | set_done_i;
      irq_q  <= (irq_q & ~(clr_irq_cmd | clr_irq_map)) | set_irq_i;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (addr == AW'(w))         rd_data = irq_q[w*DW +: DW];
      if (addr == AW'(WORDS + w)) rd_data = done_q[w*DW +: DW];
    end
  end

  assign done_o = done_q;
  assign irq_o  = irq_q;

  assert_set_done_R2: assert property (@(posedge clk) disable iff (rst)
    (|set_done_i) |=> ((done_o & $past(set_done_i)) == $past(set_done_i)));

  assert_set_irq_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (|set_irq_i) |=> ((irq_o & $past(set_irq_i)) == $past(set_irq_i)));

  assert_no_spurious_done_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((done_o & ~$past(done_o) & ~$past(set_done_i)) == '0));

  assert_skip_lane_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == CMD_ADDR && wr_be[0] && wr_data[7])
      |=> ((done_o & $past(done_o)) == $past(done_o)));

  assert_cmd_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (addr == CMD_ADDR) |-> (rd_data == '0));

  assert_done_ignores_irq_writes_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr != CMD_ADDR) |=> ((done_o & $past(done_o)) == $past(done_o)));
endmodule

// File: tb/test_dma_flag_status.sv
module test_dma_flag_status;
  logic        clk = 0;
  logic        rst = 1;
  logic [63:0] set_done_i = '0, set_irq_i = '0;
  logic        wr_en = 0;
  logic [2:0]  addr = '0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [63:0] done_o, irq_o;

  int n_chk = 0, n_bad = 0;
  logic [63:0] m_done = '0, m_irq = '0;

  dma_flag_status i_dma_flag_status (
    .clk(clk), .rst(rst), .set_done_i(set_done_i), .set_irq_i(set_irq_i),
    .wr_en(wr_en), .addr(addr), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .done_o(done_o), .irq_o(irq_o));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] f_cmd(input logic [7:0] b, input logic en);
    if (!en || b[7]) return 64'd0;
    if (b[6]) return {64{1'b1}};
    return 64'd1 << b[5:0];
  endfunction

  function automatic logic [63:0] f_map(input logic we, input logic [2:0] a,
                                        input logic [3:0] be, input logic [31:0] d);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
    if (!we) return 64'd0;
    if (a == 3'd0) return {32'd0, d & m};
    if (a == 3'd1) return {d & m, 32'd0};
    return 64'd0;
  endfunction

  function automatic logic [31:0] f_read(input logic [2:0] a);
    case (a)
      3'd0: return m_irq[31:0];
      3'd1: return m_irq[63:32];
      3'd2: return m_done[31:0];
      3'd3: return m_done[63:32];
      default: return 32'd0;
    endcase
  endfunction

  task automatic step(input string req, input logic [63:0] sd, input logic [63:0] si,
                      input logic we, input logic [2:0] a, input logic [3:0] be,
                      input logic [31:0] d);
    logic cmd;
    set_done_i = sd; set_irq_i = si; wr_en = we; addr = a; wr_be = be; wr_data = d;
    #1;
    chk({req, " R8 read"}, {32'd0, rd_data}, {32'd0, f_read(a)});
    cmd = we && a == 3'd4;
    m_done = (m_done & ~f_cmd(d[7:0], cmd && be[0])) | sd;
    m_irq  = (m_irq & ~(f_cmd(d[15:8], cmd && be[1]) | f_map(we, a, be, d))) | si;
    @(posedge clk);
    @(negedge clk);
    set_done_i = '0; set_irq_i = '0; wr_en = 0;
    chk({req, " R11 done_o"}, done_o, m_done);
    chk({req, " R11 irq_o"}, irq_o, m_irq);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] sd, si;
    logic [31:0] d;
    void'($urandom(32'd9151));
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 done", done_o, 64'd0);
    chk("R1 irq", irq_o, 64'd0);
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); #1;
      chk("R1 read", {32'd0, rd_data}, 64'd0);
    end

    step("R2 set", {64{1'b1}}, {64{1'b1}}, 0, 3'd0, 4'h0, 32'd0);
    step("R3 idx63", '0, '0, 1, 3'd4, 4'h1, 32'h0000_003F);
    step("R3 idx0", '0, '0, 1, 3'd4, 4'h1, 32'h0000_0000);
    step("R5 skip", '0, '0, 1, 3'd4, 4'h3, 32'h0000_C080);
    step("R5 be off", '0, '0, 1, 3'd4, 4'h0, 32'h0000_4040);
    step("R6 irq idx32", '0, '0, 1, 3'd4, 4'h2, 32'h0000_2080);
    step("R7 low w1c", '0, '0, 1, 3'd0, 4'h5, 32'h8001_8001);
    step("R7 high w1c", '0, '0, 1, 3'd1, 4'h8, 32'hFFFF_FFFF);
    step("R8 ign write", '0, '0, 1, 3'd2, 4'hF, 32'hFFFF_FFFF);
    step("R8 ign write", '0, '0, 1, 3'd6, 4'hF, 32'hFFFF_FFFF);
    step("R9 collide", 64'h8000_0000_0000_0001, 64'h0000_0001_0000_0000,
         1, 3'd4, 4'hF, 32'h0000_4040);
    step("R10 both", {64{1'b1}}, {64{1'b1}}, 0, 3'd0, 4'h0, 32'd0);
    step("R10 both lanes", '0, '0, 1, 3'd4, 4'h3, 32'h0000_1F05);
    step("R4 all", '0, '0, 1, 3'd4, 4'h1, 32'h0000_007F);
    step("R9 map collide", '0, 64'h0000_0000_8000_0000, 1, 3'd0, 4'hF, 32'hFFFF_FFFF);
    for (int a = 0; a < 8; a++) step("R8 scan", '0, '0, 0, 3'(a), 4'h0, 32'd0);

    for (int n = 0; n < 3000; n++) begin
      int op;
      sd = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      si = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      op = int'($urandom % 4);
      d = $urandom;
      case (op)
        0: step("R2 rand", sd, si, 0, 3'($urandom), 4'($urandom), d);
        1: step("R7 rand", sd, si, 1, 3'($urandom % 2), 4'($urandom), d);
        2: begin
          if ($urandom % 2 == 0) d[7] = 0;
          if ($urandom % 2 == 0) d[15] = 0;
          if ($urandom % 4 != 0) d[6] = 0;
          if ($urandom % 4 != 0) d[14] = 0;
          step("R10 rand", sd, si, 1, 3'd4, 4'($urandom), d);
        end
        default: step("R8 rand", sd, si, 1, 3'(2 + $urandom % 6), 4'($urandom), d);
      endcase
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule